// File: doc/BRIEF.md
# Quantized Element-Wise Compute Lane

This block is one pipelined lane of an element-wise engine that combines two quantized feature-map streams. Each cycle it can accept a left and a right integer operand, each with its own zero point and its own unsigned fixed-point scale, plus an operation code. The lane first removes each operand's zero point, then scales it into a wide signed intermediate. It then adds, subtracts or multiplies the two intermediates, or applies a sigmoid or tanh activation to the left intermediate using a lookup table.

The result is rounded and saturated into a signed fixed-point output word. Arithmetic results carry 10 fractional bits. Activation results carry 16 fractional bits. A valid pulse travels with every result. The result register holds its value between pulses, so a downstream collector can sample it whenever the pulse appears.

Scales are unsigned with 12 fractional bits. The activation table has 256 entries and spans left intermediates from -8.0 to just under +8.0 in steps of 1/16.

Top module: `ew_lane`

## Requirements
- R1: During and right after a synchronous active-high reset, `out_valid` is 0 and `out_data` is 0.
- R2: Each cycle with `in_valid` high yields exactly one `out_valid` pulse three clock edges later, and `out_valid` never rises without such an input. Inputs on consecutive cycles give results on consecutive cycles.
- R3: Each operand is dequantized as (operand − zero point) × scale. All three are read as integers: operand and zero point signed, scale unsigned. The product carries 12 fractional bits.
- R4: Code 0 (add) outputs cast(L + R, 2). Here L and R are the dequantized intermediates, and cast(v, k) divides v by 2^k, rounds and saturates, which gives 10 output fractional bits.
- R5: Code 1 (subtract) outputs cast(L − R, 2), that is, left minus right.
- R6: Code 2 (multiply) outputs cast(L × R, 14).
- R7: Codes 3 (sigmoid) and 4 (tanh) output a table entry with 16 fractional bits, chosen by the left intermediate. The index is floor(L / 256) + 128, and entry i equals round(2^16 · f((i − 128)/16)). The right operand and its zero point and scale have no effect on the result.
- R8: In activation modes, a left intermediate beyond the table span clamps the index to 0 (below) or 255 (above).
- R9: Every cast rounds halves away from zero: +0.5 becomes +1 and −0.5 becomes −1.
- R10: Every cast saturates to the signed 24-bit range [−8388608, 8388607].
- R11: Codes 5, 6 and 7 are reserved. They produce a result of 0, with a valid pulse.
- R12: While `out_valid` is low, `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_op | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 sigmoid, 4 tanh, 5–7 reserved) |
| lhs | input | 8 | Left operand, signed |
| rhs | input | 8 | Right operand, signed |
| lhs_zp | input | 8 | Left zero point, signed |
| rhs_zp | input | 8 | Right zero point, signed |
| lhs_scale | input | 16 | Left scale, unsigned, 12 fractional bits |
| rhs_scale | input | 16 | Right scale, unsigned, 12 fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 24 | Signed fixed-point result, held between strobes |

## Verification
Operands driven on a falling edge are captured at the next rising edge. Their result and strobe appear after the third rising edge, so the bench files each expected result under the cycle index three steps ahead of the drive cycle. On every falling edge, the bench compares the strobe with whether a result is filed for that cycle. It compares the data word with the filed value, or with the last filed value when none is due. This per-cycle comparison catches any early, late, missing or extra pulse, as well as any data change between pulses.

// File: rtl/ew_pkg.sv
package ew_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_SIG  = 3'd3,
        OP_TANH = 3'd4
    } ew_op_e;

    typedef struct packed {
        logic       vld;
        logic [2:0] op;
    } ew_ctl_t;

    function automatic logic op_is_act(input logic [2:0] op);
        return (op == OP_SIG) || (op == OP_TANH);
    endfunction

    function automatic logic op_is_reserved(input logic [2:0] op);
        return op > OP_TANH;
    endfunction

    // Divide by 2^sh, round half away from zero, clamp to signed ow bits.
    function automatic longint round_sat(input longint v, input int sh, input int ow);
        longint mag, q, hi, lo;
        mag = (v < 0) ? -v : v;
        if (sh > 0)
            q = (mag + (longint'(1) <<< (sh - 1))) >>> sh;
        else
            q = mag;
        if (v < 0)
            q = -q;
        hi = (longint'(1) <<< (ow - 1)) - 1;
        lo = -(longint'(1) <<< (ow - 1));
        if (q > hi)
            q = hi;
        else if (q < lo)
            q = lo;
        return q;
    endfunction

endpackage

// File: rtl/ew_dequant.sv
module ew_dequant #(
    parameter int DW = 8,
    parameter int SW = 16,
    localparam int DDW = DW + 1,
    localparam int SDW = DDW + SW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DW-1:0]         x,
    input  logic [DW-1:0]         zp,
    input  logic [SW-1:0]         scale,
    input  logic                  force_zero,
    output logic signed [SDW-1:0] scaled
);

    logic signed [DDW-1:0] diff_q;
    logic        [SW-1:0]  scale_q;
    logic        [DW-1:0]  x_eff;

    assign x_eff = force_zero ? '0 : x;

    // Stage 1: zero-point removal.
    always_ff @(posedge clk) begin
        if (rst) begin
            diff_q  <= '0;
            scale_q <= '0;
        end else begin
            diff_q  <= $signed({x_eff[DW-1], x_eff}) - $signed({zp[DW-1], zp});
            scale_q <= scale;
        end
    end

    // Stage 2: scaling into the wide intermediate.
    always_ff @(posedge clk) begin
        if (rst)
            scaled <= '0;
        else
            scaled <= SDW'(diff_q) * $signed({1'b0, scale_q});
    end

endmodule

// File: rtl/ew_act_lut.sv
module ew_act_lut #(
    parameter int SDW    = 26,
    parameter int SF     = 12,
    parameter int ABITS  = 8,
    parameter int IN_INT = 3,
    parameter int LW     = 18,
    parameter int LFRAC  = 16,
    localparam int DEPTH   = 1 << ABITS,
    localparam int STEP_SH = SF + IN_INT + 1 - ABITS
) (
    input  logic signed [SDW-1:0] sa,
    input  logic                  use_tanh,
    output logic signed [LW-1:0]  entry
);

    typedef logic signed [LW-1:0] tab_t [DEPTH];

    function automatic tab_t build_tab(input bit th);
        tab_t t;
        real  x, y;
        for (int i = 0; i < DEPTH; i++) begin
            x = real'(i - DEPTH / 2) * (2.0 ** (STEP_SH - SF));
            y = th ? $tanh(x) : 1.0 / (1.0 + $exp(-x));
            t[i] = LW'(longint'(y * (2.0 ** LFRAC)));
        end
        return t;
    endfunction

    localparam tab_t SIG_TAB  = build_tab(1'b0);
    localparam tab_t TANH_TAB = build_tab(1'b1);

    localparam logic signed [SDW-1:0] T_LO = SDW'(-(DEPTH / 2));
    localparam logic signed [SDW-1:0] T_HI = SDW'(DEPTH / 2 - 1);

    logic signed [SDW-1:0] coarse;
    logic signed [SDW-1:0] clamped;
    logic [ABITS-1:0]      idx;

    always_comb begin
        coarse = sa >>> STEP_SH;
        if (coarse < T_LO)
            clamped = T_LO;
        else if (coarse > T_HI)
            clamped = T_HI;
        else
            clamped = coarse;
        idx   = ABITS'(clamped + SDW'(DEPTH / 2));
        entry = use_tanh ? TANH_TAB[idx] : SIG_TAB[idx];
    end

    // R8: out-of-span intermediates land on the end entries.
    always_comb begin
        if (!$isunknown(sa) && (sa >= (SDW'(DEPTH / 2) <<< STEP_SH)))
            a_r8_clamp_hi: assert (idx == ABITS'(DEPTH - 1));
        if (!$isunknown(sa) && (sa < -(SDW'(DEPTH / 2) <<< STEP_SH)))
            a_r8_clamp_lo: assert (idx == '0);
    end

endmodule

// File: rtl/ew_cast_stage.sv
module ew_cast_stage
    import ew_pkg::*;
#(
    parameter int SDW    = 26,
    parameter int SF     = 12,
    parameter int LW     = 18,
    parameter int OW     = 24,
    parameter int AFRAC  = 10,
    parameter int XFRAC  = 16,
    parameter int LFRAC  = 16,
    localparam int SH_ADD = SF - AFRAC,
    localparam int SH_MUL = 2 * SF - AFRAC,
    localparam int SH_ACT = LFRAC - XFRAC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ew_ctl_t               ctl,
    input  logic signed [SDW-1:0] sa,
    input  logic signed [SDW-1:0] sb,
    input  logic signed [LW-1:0]  act_val,
    output logic                  out_valid,
    output logic [OW-1:0]         out_data
);

    longint la, lb, cast_v;

    always_comb begin
        la = longint'(sa);
        lb = longint'(sb);
        unique case (ctl.op)
            OP_ADD:  cast_v = round_sat(la + lb, SH_ADD, OW);
            OP_SUB:  cast_v = round_sat(la - lb, SH_ADD, OW);
            OP_MUL:  cast_v = round_sat(la * lb, SH_MUL, OW);
            OP_SIG,
            OP_TANH: cast_v = round_sat(longint'(act_val), SH_ACT, OW);
            default: cast_v = 0;
        endcase
    end

    // Stage 3: operate and cast; the result register loads only on a valid.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.vld;
            if (ctl.vld)
                out_data <= OW'(cast_v);
        end
    end

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl.vld && op_is_reserved(ctl.op)) |=> (out_data == '0));

    a_r12_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !ctl.vld |=> $stable(out_data));

endmodule

// File: rtl/ew_lane.sv
module ew_lane
    import ew_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SW     = 16,
    parameter int SF     = 12,
    parameter int OW     = 24,
    parameter int AFRAC  = 10,
    parameter int XFRAC  = 16,
    parameter int ABITS  = 8,
    parameter int IN_INT = 3,
    localparam int SDW   = DW + 1 + SW + 1,
    localparam int LW    = XFRAC + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic [DW-1:0] lhs_zp,
    input  logic [DW-1:0] rhs_zp,
    input  logic [SW-1:0] lhs_scale,
    input  logic [SW-1:0] rhs_scale,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    ew_ctl_t ctl_s1, ctl_s2;
    logic signed [SDW-1:0] sa, sb;
    logic signed [LW-1:0]  act_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_s1 <= '0;
            ctl_s2 <= '0;
        end else begin
            ctl_s1 <= '{vld: in_valid, op: in_op};
            ctl_s2 <= ctl_s1;
        end
    end

    ew_dequant #(.DW(DW), .SW(SW)) u_deq_l (
        .clk(clk), .rst(rst), .x(lhs), .zp(lhs_zp), .scale(lhs_scale),
        .force_zero(1'b0), .scaled(sa)
    );

    ew_dequant #(.DW(DW), .SW(SW)) u_deq_r (
        .clk(clk), .rst(rst), .x(rhs), .zp(rhs_zp), .scale(rhs_scale),
        .force_zero(op_is_act(in_op)), .scaled(sb)
    );

    ew_act_lut #(
        .SDW(SDW), .SF(SF), .ABITS(ABITS), .IN_INT(IN_INT),
        .LW(LW), .LFRAC(XFRAC)
    ) u_lut (
        .sa(sa), .use_tanh(ctl_s2.op == OP_TANH), .entry(act_val)
    );

    ew_cast_stage #(
        .SDW(SDW), .SF(SF), .LW(LW), .OW(OW),
        .AFRAC(AFRAC), .XFRAC(XFRAC), .LFRAC(XFRAC)
    ) u_cast (
        .clk(clk), .rst(rst), .ctl(ctl_s2), .sa(sa), .sb(sb),
        .act_val(act_val), .out_valid(out_valid), .out_data(out_data)
    );

    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

endmodule

// File: tb/tb_ew_lane.sv
module tb_ew_lane;

    localparam int CLK_PERIOD = 10;
    localparam int OW = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [7:0]  lhs, rhs, lhs_zp, rhs_zp;
    logic [15:0] lhs_scale, rhs_scale;
    logic        out_valid;
    logic [23:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [23:0] held = '0;

    bit          exp_v   [int];
    logic [23:0] exp_d   [int];
    string       exp_tag [int];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ew_lane dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .lhs(lhs), .rhs(rhs), .lhs_zp(lhs_zp), .rhs_zp(rhs_zp),
        .lhs_scale(lhs_scale), .rhs_scale(rhs_scale),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint ref_cast(input longint v, input int sh);
        longint d, q, r, lim;
        d = longint'(1) << sh;
        q = v / d;
        r = v - q * d;
        if (2 * (r < 0 ? -r : r) >= d && sh > 0) q = q + (v < 0 ? -1 : 1);
        lim = longint'(1) << (OW - 1);
        if (q > lim - 1) q = lim - 1;
        if (q < -lim) q = -lim;
        return q;
    endfunction

    function automatic longint ref_act(input longint l, input bit th);
        longint t;
        real x, y;
        t = l / 256;
        if (l < 0 && t * 256 != l) t = t - 1;
        if (t < -128) t = -128;
        if (t > 127) t = 127;
        x = real'(t) / 16.0;
        y = th ? $tanh(x) : 1.0 / (1.0 + $exp(-x));
        return longint'(y * 65536.0);
    endfunction

    function automatic longint model(input int op, input int a, input int b,
                                     input int za, input int zb, input int ka, input int kb);
        longint l, r;
        l = longint'(a - za) * longint'(ka);
        r = longint'(b - zb) * longint'(kb);
        case (op)
            0: return ref_cast(l + r, 2);
            1: return ref_cast(l - r, 2);
            2: return ref_cast(l * r, 14);
            3: return ref_act(l, 1'b0);
            4: return ref_act(l, 1'b1);
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, expv);
        end
    endtask

    // One cycle: compare outputs at the falling edge, then drive the next inputs.
    task automatic step(input bit v, input int op, input int a, input int b,
                        input int za, input int zb, input int ka, input int kb,
                        input string tag);
        bit due;
        @(negedge clk);
        cyc++;
        due = exp_v.exists(cyc);
        check(out_valid == due, "R2", out_valid, due);
        if (due) begin
            held = exp_d[cyc];
            check(out_data == held, exp_tag[cyc], $signed(out_data), $signed(held));
        end else begin
            check(out_data == held, "R12", $signed(out_data), $signed(held));
        end
        in_valid  = v;
        in_op     = 3'(op);
        lhs       = 8'(a);
        rhs       = 8'(b);
        lhs_zp    = 8'(za);
        rhs_zp    = 8'(zb);
        lhs_scale = 16'(ka);
        rhs_scale = 16'(kb);
        if (v) begin
            exp_v[cyc + 3]   = 1'b1;
            exp_d[cyc + 3]   = 24'(model(op, a, b, za, zb, ka, kb));
            exp_tag[cyc + 3] = tag;
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3, 4: return "R7";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_op = 0; lhs = 0; rhs = 0;
        lhs_zp = 0; rhs_zp = 0; lhs_scale = 0; rhs_scale = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_data == '0, "R1", out_data, 0);
        rst = 1'b0;

        // R3: zero points and scales applied per operand
        step(1, 0, 20, -5, 4, -7, 4096, 8192, "R3");
        step(1, 0, -100, 50, -20, 10, 1234, 777, "R3");
        // R4/R5/R6 basic, back to back
        step(1, 0, 3, 4, 0, 0, 4096, 4096, "R4");
        step(1, 1, 3, 4, 0, 0, 4096, 4096, "R5");
        step(1, 2, 3, -4, 0, 0, 4096, 4096, "R6");
        // R9: halves round away from zero (+0.5 and -0.5)
        step(1, 0, 1, 1, 0, 0, 1, 1, "R9");
        step(1, 1, 0, 2, 0, 0, 1, 1, "R9");
        step(1, 0, 1, 0, 0, 0, 1, 1, "R9");
        // R10: saturation both signs
        step(1, 2, 127, 127, -128, -128, 65535, 65535, "R10");
        step(1, 2, -128, 127, 127, -128, 65535, 65535, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R12");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R12");
        // R8: clamp to end entries
        step(1, 3, 127, 0, -128, 0, 65535, 0, "R8");
        step(1, 4, -128, 0, 127, 0, 65535, 0, "R8");
        step(1, 3, -128, 0, 127, 0, 65535, 0, "R8");
        // R7: activation ignores right side (same left, different right)
        step(1, 4, 9, -100, 2, 33, 5000, 60000, "R7");
        step(1, 4, 9, 120, 2, -9, 5000, 3, "R7");
        step(1, 3, -3, 0, 0, 0, 4096, 0, "R7");
        // R11: reserved codes
        step(1, 5, 50, 50, 0, 0, 4096, 4096, "R11");
        step(1, 7, -9, 3, 1, 1, 100, 100, "R11");
        repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, "R12");

        for (int i = 0; i < 400; i++) begin
            automatic int op = $urandom_range(0, 7);
            automatic bit v  = ($urandom_range(0, 3) != 0);
            step(v, op, $signed(8'($urandom)), $signed(8'($urandom)),
                 $signed(8'($urandom)), $signed(8'($urandom)),
                 $urandom_range(0, 65535), $urandom_range(0, 65535), op_tag(op));
        end
        repeat (5) step(0, 0, 0, 0, 0, 0, 0, 0, "R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule